// File: doc/BRIEF.md
# Parallel NOR Flash Host Bus Front End

This block sits between the host-facing pins of a parallel NOR flash and its internal command logic. It samples the active-low chip select, read strobe, write strobe, hardware reset pin and the width select through two-stage synchronizers. From these samples it rebuilds the write cycles that the host drives with bus-style timing. Each accepted write becomes a one-clock event that carries the captured address, the data and a byte-mode flag.

On reads it passes the synchronized address to an internal read port. It then drives the returned word back onto the 16-bit data bus through per-bit output enables.

The bus has two widths. With the width select high, all sixteen data pins carry data. With it low, only the lower eight carry data, pins 8 to 14 float, and pin 15 serves as the least significant byte-address bit. A write strobe is formed from chip select and write strobe together. The address is taken where the later of the two falls, and the data where the earlier of the two rises. Strobes that stay low for only a few sample clocks are rejected.

Top module: `nor_bus_front`

## Requirements
- R1: With `wide` high a read enables all 16 bits of `dq_oe`. With `wide` low only `dq_oe[7:0]` are enabled, `dq_oe[15:8]` are 0 and `dq_out[15:8]` are 0.
- R2: A word-mode write reports `wr_addr = {1'b0, addr}` and `wr_data` equal to all 16 data pins. A byte-mode write reports `wr_addr = {addr, dq_in[15]}` and `wr_data = {8'h00, dq_in[7:0]}`, and `wr_byte` is 1 only for byte-mode writes.
- R3: A write is accepted only while `ce_n` and `we_n` are both low and `oe_n` is high. A low `oe_n` at any point of the low phase cancels the write.
- R4: The strobe is the OR of `ce_n` and `we_n`. The address and A-1 are taken when the strobe falls, which is the later of the two falling. The data is taken when the strobe rises, which is the earlier of the two rising. Address changes after the fall and data changes after the rise do not alter the event.
- R5: `dq_oe` is 0 whenever `oe_n` is high, `ce_n` is high or `rp_n` is low.
- R6: Each accepted write produces exactly one `wr_valid` pulse, one clock wide, in the third clock after the strobe rise reaches the pins.
- R7: A strobe low phase shorter than `MIN_LOW` sample clocks produces no write event. A phase of exactly `MIN_LOW` clocks is accepted.
- R8: While `rp_n` is low any started write is dropped and none starts. If the strobe is already low when `rp_n` is released, its following rise is not taken as a write.
- R9: Read data appears two clocks after the pins settle. In word mode `dq_out` equals `rd_data`. In byte mode `dq_out[7:0]` is `rd_data[15:8]` when `dq_in[15]` is 1 and `rd_data[7:0]` when it is 0.
- R10: `rd_addr` equals the synchronized `addr` pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset of the sampling logic |
| ce_n | input | 1 | Chip select pin, active low |
| oe_n | input | 1 | Read strobe pin, active low |
| we_n | input | 1 | Write strobe pin, active low |
| rp_n | input | 1 | Hardware reset pin, active low |
| wide | input | 1 | Width select: 1 = 16-bit, 0 = 8-bit |
| addr | input | AW | Word address pins |
| dq_in | input | 16 | Data pins as seen from the bus; bit 15 is A-1 in byte mode |
| dq_out | output | 16 | Data driven onto the bus |
| dq_oe | output | 16 | Per-bit output enables |
| rd_addr | output | AW | Address to the internal read port |
| rd_data | input | 16 | Word returned by the read port |
| wr_valid | output | 1 | One-clock write event |
| wr_addr | output | AW+1 | Captured write address |
| wr_data | output | 16 | Captured write data |
| wr_byte | output | 1 | Write event came from byte mode |

## Verification
Pins move only on falling clock edges. Read results (`dq_out`, `dq_oe`, `rd_addr`) are due two rising edges after the pins change, and the bench samples them at the third falling edge. A write event is due three rising edges after the strobe rise. The bench counts `wr_valid` pulses with a falling-edge monitor and checks the count and the captured values six clocks after each rise, so a late, doubled or missing pulse shows up as a wrong count. The cases where no write is expected (glitch, read strobe low, reset pin) are checked with the same count after the same window.

// File: rtl/nor_bus_front.sv
module nor_bus_front #(
  parameter int AW      = 17,
  parameter int MIN_LOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          rp_n,
  input  logic          wide,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [15:0]   dq_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data,
  output logic          wr_valid,
  output logic [AW:0]   wr_addr,
  output logic [15:0]   wr_data,
  output logic          wr_byte
);
  localparam int SW = AW + 21;
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [SW-1:0] SYNC_RST = {5'b11101, {(AW+16){1'b0}}};

  logic [SW-1:0] s1, s2;
  logic ce_s, oe_s, we_s, rp_s, wide_s;
  logic [AW-1:0] addr_s;
  logic [15:0] dq_s;
  logic strb_s, strb_q, in_cyc, lat_byte, fall, rise, rd_en;
  logic [CW-1:0] cnt;
  logic [AW:0] lat_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= SYNC_RST;
      s2 <= SYNC_RST;
    end else begin
      s1 <= {ce_n, oe_n, we_n, rp_n, wide, addr, dq_in};
      s2 <= s1;
    end
  end

  assign {ce_s, oe_s, we_s, rp_s, wide_s, addr_s, dq_s} = s2;
  assign strb_s = ce_s | we_s;
  assign fall   = rp_s & oe_s & strb_q & ~strb_s;
  assign rise   = strb_s & ~strb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q   <= 1'b0;
      in_cyc   <= 1'b0;
      cnt      <= '0;
      lat_addr <= '0;
      lat_byte <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_byte  <= 1'b0;
    end else begin
      strb_q   <= strb_s;
      wr_valid <= 1'b0;
      if (!rp_s || !oe_s) begin
        in_cyc <= 1'b0;
      end else if (fall) begin
        in_cyc   <= 1'b1;
        cnt      <= CW'(1);
        lat_addr <= wide_s ? {1'b0, addr_s} : {addr_s, dq_s[15]};
        lat_byte <= ~wide_s;
      end else if (in_cyc && !strb_s) begin
        if (cnt < CW'(MIN_LOW)) cnt <= cnt + 1'b1;
      end else if (in_cyc && rise) begin
        in_cyc <= 1'b0;
        if (cnt >= CW'(MIN_LOW)) begin
          wr_valid <= 1'b1;
          wr_addr  <= lat_addr;
          wr_data  <= lat_byte ? {8'h00, dq_s[7:0]} : dq_s;
          wr_byte  <= lat_byte;
        end
      end
    end
  end

  assign rd_addr = addr_s;
  assign rd_en   = rp_s & ~ce_s & ~oe_s;
  assign dq_oe   = {{8{rd_en & wide_s}}, {8{rd_en}}};
  assign dq_out  = wide_s ? rd_data
                          : {8'h00, dq_s[15] ? rd_data[15:8] : rd_data[7:0]};
endmodule

// File: rtl/nor_bus_front_chk.sv
module nor_bus_front_chk #(
  parameter int AW = 17
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rp_s,
  input logic        oe_s,
  input logic        ce_s,
  input logic        wide_s,
  input logic        strb_s,
  input logic        strb_q,
  input logic [15:0] dq_oe,
  input logic        wr_valid,
  input logic        wr_byte,
  input logic [AW:0] wr_addr
);
  AST_HIZ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_s || ce_s || !rp_s) |-> dq_oe == 16'h0000); // R5
  AST_UPPER_OFF_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_s |-> dq_oe[15:8] == 8'h00); // R1
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R6
  AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> ($past(strb_s) && !$past(strb_q))); // R4
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_s |=> !wr_valid); // R8
  AST_WORD_ADDR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_byte) |-> !wr_addr[AW]); // R2
endmodule

bind nor_bus_front nor_bus_front_chk #(.AW(AW)) u_chk (.*);

// File: tb/nor_bus_front_test.sv
module nor_bus_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int MIN_LOW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b0, wide = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe, rd_data, wr_data;
  logic [AW-1:0] rd_addr;
  logic wr_valid, wr_byte;
  logic [AW:0] wr_addr;

  int errors = 0, checks = 0, ev_cnt = 0;
  logic [AW:0] ev_addr;
  logic [15:0] ev_data;
  logic ev_byte;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[16], 15'h0};
  endfunction

  assign rd_data = mem(rd_addr);

  nor_bus_front #(.AW(AW), .MIN_LOW(MIN_LOW)) uut (.*);

  always @(negedge clk) if (wr_valid) begin
    ev_cnt++; ev_addr = wr_addr; ev_data = wr_data; ev_byte = wr_byte;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input bit byte_m, input logic [AW-1:0] a, input bit am1);
    logic [15:0] m, eo, ed;
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; wide = !byte_m; addr = a;
    dq_in = {am1, 15'h0};
    idle(3);
    m  = mem(a);
    eo = byte_m ? 16'h00FF : 16'hFFFF;
    ed = byte_m ? {8'h00, am1 ? m[15:8] : m[7:0]} : m;
    check(dq_oe == eo, "R1 read enables", dq_oe, eo);
    check(dq_out == ed, "R9 read data", dq_out, ed);
    check(rd_addr == a, "R10 read address", rd_addr, a);
    ce_n = 1; oe_n = 1;
    idle(3);
    check(dq_oe == 16'h0, "R5 idle hi-z", dq_oe, 0);
  endtask

  // Drives one write; low_len = clocks with both strobes low; oe_mid pulls oe low midway
  task automatic do_write(input bit byte_m, input logic [AW-1:0] a, input bit am1,
                          input logic [15:0] d, input bit ce_first, input int low_len,
                          input bit oe_mid);
    @(negedge clk);
    wide = !byte_m; oe_n = 1; ce_n = 1; we_n = 1;
    addr = AW'($urandom); dq_in = 16'($urandom);
    @(negedge clk);
    if (ce_first) ce_n = 0; else we_n = 0;
    @(negedge clk);
    addr = a;
    dq_in = byte_m ? {am1, 7'($urandom), d[7:0]} : d;
    @(negedge clk);
    ce_n = 0; we_n = 0;
    for (int i = 0; i < low_len; i++) begin
      @(negedge clk);
      addr = AW'($urandom);
      if (byte_m) dq_in[15] = 1'($urandom);
      if (oe_mid && i == 0) oe_n = 0;
    end
    if (ce_first) we_n = 1; else ce_n = 1;
    @(negedge clk);
    dq_in = 16'($urandom);
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  function automatic logic [AW:0] exp_addr(input bit byte_m, input logic [AW-1:0] a, input bit am1);
    return byte_m ? {a, am1} : {1'b0, a};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(1234));
    idle(3);
    rst_n = 1;
    idle(3);
    check(dq_oe == 16'h0 && !wr_valid, "R5 reset state", {dq_oe, 15'h0, wr_valid}, 0);

    // R8 power-up: strobe low when reset pin released
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = 17'h00123; dq_in = 16'h1111;
    idle(3); rp_n = 1; idle(5);
    ce_n = 1; we_n = 1; idle(6);
    check(ev_cnt == 0, "R8 power-up strobe ignored", ev_cnt, 0);

    // R2/R4/R6 directed word and byte writes
    base = ev_cnt;
    do_write(0, 17'h1ABCD, 0, 16'hBEEF, 1, 4, 0); idle(6);
    check(ev_cnt == base + 1, "R6 one pulse", ev_cnt - base, 1);
    check(ev_addr == 18'h1ABCD && ev_data == 16'hBEEF && !ev_byte, "R2 word write",
          {ev_addr[15:0], ev_data}, 32'hABCDBEEF);
    base = ev_cnt;
    do_write(1, 17'h0F0F0, 1, 16'h77A5, 0, 4, 0); idle(6);
    check(ev_cnt == base + 1 && ev_addr == {17'h0F0F0, 1'b1}, "R4 byte address at fall",
          ev_addr, {17'h0F0F0, 1'b1});
    check(ev_data == 16'h00A5 && ev_byte, "R2 byte data", ev_data, 16'h00A5);

    // R7 glitch filter boundary
    base = ev_cnt;
    do_write(0, 17'h00011, 0, 16'h1234, 1, MIN_LOW - 1, 0); idle(6);
    check(ev_cnt == base, "R7 short strobe rejected", ev_cnt - base, 0);
    do_write(0, 17'h00022, 0, 16'h4321, 0, MIN_LOW, 0); idle(6);
    check(ev_cnt == base + 1 && ev_data == 16'h4321, "R7 minimum strobe accepted", ev_data, 16'h4321);

    // R3 read strobe low cancels
    base = ev_cnt;
    do_write(0, 17'h00033, 0, 16'h5555, 1, 5, 1); idle(6);
    check(ev_cnt == base, "R3 oe low inhibits write", ev_cnt - base, 0);
    // R3 read strobe low from the start
    @(negedge clk); oe_n = 0; ce_n = 0; we_n = 0; idle(6); ce_n = 1; we_n = 1; idle(2); oe_n = 1; idle(6);
    check(ev_cnt == base, "R3 read cycle no write", ev_cnt - base, 0);

    // R8 reset pin mid-cycle
    @(negedge clk); oe_n = 1; ce_n = 0; we_n = 0; addr = 17'h00044; idle(5);
    rp_n = 0; idle(4); rp_n = 1; idle(4); ce_n = 1; we_n = 1; idle(6);
    check(ev_cnt == base, "R8 reset pin drops write", ev_cnt - base, 0);
    @(negedge clk); ce_n = 0; oe_n = 0; rp_n = 0; idle(4);
    check(dq_oe == 16'h0, "R5 reset pin hi-z", dq_oe, 0);
    rp_n = 1; ce_n = 1; oe_n = 1; idle(4);

    // Directed reads
    do_read(0, 17'h12345, 0);
    do_read(1, 17'h0AAAA, 1);
    do_read(1, 17'h0AAAA, 0);

    // Random writes and reads
    for (int k = 0; k < 40; k++) begin
      bit bm, a1, cf;
      logic [AW-1:0] a;
      logic [15:0] d;
      int ln;
      logic [15:0] ed;
      bm = 1'($urandom); a1 = 1'($urandom); cf = 1'($urandom);
      a = AW'($urandom); d = 16'($urandom); ln = MIN_LOW + int'($urandom % 4);
      base = ev_cnt;
      do_write(bm, a, a1, d, cf, ln, 0); idle(6);
      ed = bm ? {8'h00, d[7:0]} : d;
      check(ev_cnt == base + 1, "R6 random pulse count", ev_cnt - base, 1);
      check(ev_addr == exp_addr(bm, a, a1) && ev_data == ed && ev_byte == bm,
            "R4 random write capture", {ev_addr[15:0], ev_data}, {exp_addr(bm, a, a1)[15:0], ed});
    end
    for (int k = 0; k < 30; k++)
      do_read(1'($urandom), AW'($urandom), 1'($urandom));

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule